// File: doc/BRIEF.md
# Status Flag Register and Condition Predicate

This block keeps the four processor status flags (negative, zero, carry, overflow) and runs the 32-bit integer operations that can change them. An operation request carries a 4-bit operation code, two operands, the carry-out of an external shifter, and a set-flags bit. The block returns the result combinationally, with a strobe that says whether the result is to be written back. On the next rising clock edge it updates the flag register, but only when the operation is of the compare type or the set-flags bit is high.

A second, purely combinational path takes a 4-bit condition code and the registered flags. It reports whether a conditionally executed instruction or branch may proceed. It also flags the one encoding that is reserved.

Top module: `flag_predicate_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags. `flags_q` is packed as {N,Z,C,V}, so N is bit 3 and V is bit 0.
- R2: The flags keep their value when `op_valid` is low, or when a non-compare operation has `set_flags` low.
- R3: The compare-type operations always update the flags and hold `wr_result` low. They are TST=8 (a AND b), TEQ=9 (a XOR b), CMP=10 (a−b) and CMN=11 (a+b). All other valid codes except 15 raise `wr_result`.
- R4: ADD=3 gives a+b, SUB=2 gives a−b and RSB=14 gives b−a. C is the carry out of the addition, so for a subtraction C=1 means that no borrow occurred.
- R5: On an arithmetic operation, V is set when both addend operands (b inverted for a subtraction) have the same sign and the sign of the result differs from it.
- R6: ADC=4 gives a+b+C and SBC=5 gives a−b−(1−C), where C is the registered carry flag.
- R7: The logical operations are AND=0, EOR=1, ORR=6, MOV=7 (result b), BIC=12 (a AND NOT b) and MVN=13 (NOT b), together with TST and TEQ. They set N and Z from the result, load C from `shift_carry`, and leave V unchanged.
- R8: Condition codes 0..7 test one flag each: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0.
- R9: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R10: Code 10 passes when N=V and code 11 when N≠V. Code 12 passes when Z=0 and N=V. Code 13 passes when Z=1 or N≠V.
- R11: Code 14 always passes. Code 15 never passes and raises `cond_undef`. `cond_undef` is low for every other code.
- R12: Operation code 15 returns zero, holds `wr_result` low and leaves the flags unchanged even with `set_flags` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (shifter output) |
| shift_carry | input | 1 | Shifter carry-out, used as C by logical operations |
| set_flags | input | 1 | Update the flags for a non-compare operation |
| result | output | 32 | Operation result |
| wr_result | output | 1 | Result is to be written back |
| flags_q | output | 4 | Registered flags {N,Z,C,V} |
| cond | input | 4 | Condition code to evaluate |
| cond_pass | output | 1 | Condition holds on current flags |
| cond_undef | output | 1 | Condition code is the reserved one |

## Verification
A wrong flag-register state appears at the ports at once: `cond_pass` is combinational from the register, so the next sweep of the sixteen condition codes exposes it. A wrong carry also shows in the very next ADC or SBC result. The bench applies each vector and checks the result and the write strobe before the clock edge. It then checks the flags and every condition code one cycle later, so an error in either the arithmetic or the predicate is seen within a single vector. Operations that must not touch the flags are placed right after vectors that leave distinctive values, so an illegal update changes a visible bit.

// File: rtl/flag_predicate_unit.sv
module flag_predicate_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         shift_carry,
  input  logic         set_flags,
  output logic [W-1:0] result,
  output logic         wr_result,
  output logic [3:0]   flags_q,
  input  logic [3:0]   cond,
  output logic         cond_pass,
  output logic         cond_undef
);

  localparam int MSB = W - 1;

  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags_q;

  logic         is_cmp, is_logic, is_rsvd;
  logic [W-1:0] x_op, y_op, logic_res;
  logic         cin;
  logic [W:0]   sum;
  logic         arith_v;
  logic         flag_we;
  logic [3:0]   flags_d;

  assign is_cmp  = (op_sel[3:2] == 2'b10);
  assign is_rsvd = (op_sel == 4'd15);

  always_comb begin
    is_logic  = 1'b1;
    logic_res = '0;
    x_op      = opnd_a;
    y_op      = opnd_b;
    cin       = 1'b0;
    unique case (op_sel)
      4'd0, 4'd8: logic_res = opnd_a & opnd_b;
      4'd1, 4'd9: logic_res = opnd_a ^ opnd_b;
      4'd6:       logic_res = opnd_a | opnd_b;
      4'd7:       logic_res = opnd_b;
      4'd12:      logic_res = opnd_a & ~opnd_b;
      4'd13:      logic_res = ~opnd_b;
      4'd2, 4'd10: begin is_logic = 1'b0; y_op = ~opnd_b; cin = 1'b1; end
      4'd3, 4'd11: begin is_logic = 1'b0; end
      4'd4:        begin is_logic = 1'b0; cin = fc; end
      4'd5:        begin is_logic = 1'b0; y_op = ~opnd_b; cin = fc; end
      4'd14:       begin is_logic = 1'b0; x_op = opnd_b; y_op = ~opnd_a; cin = 1'b1; end
      default:     logic_res = '0;
    endcase
  end

  assign sum     = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, cin};
  assign arith_v = (x_op[MSB] == y_op[MSB]) && (sum[MSB] != x_op[MSB]);

  assign result    = is_rsvd ? '0 : (is_logic ? logic_res : sum[MSB:0]);
  assign wr_result = op_valid && !is_cmp && !is_rsvd;
  assign flag_we   = op_valid && !is_rsvd && (is_cmp || set_flags);

  assign flags_d = is_logic
    ? {result[MSB], (result == '0), shift_carry, fv}
    : {result[MSB], (result == '0), sum[W], arith_v};

  always_ff @(posedge clk) begin
    if (rst)          flags_q <= 4'b0000;
    else if (flag_we) flags_q <= flags_d;
  end

  always_comb begin
    cond_undef = 1'b0;
    unique case (cond)
      4'd0:  cond_pass = fz;
      4'd1:  cond_pass = !fz;
      4'd2:  cond_pass = fc;
      4'd3:  cond_pass = !fc;
      4'd4:  cond_pass = fn;
      4'd5:  cond_pass = !fn;
      4'd6:  cond_pass = fv;
      4'd7:  cond_pass = !fv;
      4'd8:  cond_pass = fc && !fz;
      4'd9:  cond_pass = !fc || fz;
      4'd10: cond_pass = (fn == fv);
      4'd11: cond_pass = (fn != fv);
      4'd12: cond_pass = !fz && (fn == fv);
      4'd13: cond_pass = fz || (fn != fv);
      4'd14: cond_pass = 1'b1;
      default: begin cond_pass = 1'b0; cond_undef = 1'b1; end
    endcase
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (flags_q == 4'b0000));

  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || (!is_cmp && !set_flags)) |=> $stable(flags_q));

  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_cmp) |-> !wr_result);

  assert_logic_keeps_v_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_logic && flag_we) |=> (flags_q[0] == $past(flags_q[0])));

  assert_always_taken_R11: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'd14) |-> (cond_pass && !cond_undef));

  assert_reserved_cond_R11: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'd15) |-> (!cond_pass && cond_undef));

  assert_rsvd_op_R12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_rsvd) |=> $stable(flags_q));

endmodule

// File: tb/test_flag_predicate_unit.sv
module test_flag_predicate_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic        shift_carry, set_flags;
  logic [31:0] result;
  logic        wr_result;
  logic [3:0]  flags_q;
  logic [3:0]  cond;
  logic        cond_pass, cond_undef;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  flag_predicate_unit i_flag_predicate_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_carry(shift_carry),
    .set_flags(set_flags), .result(result), .wr_result(wr_result),
    .flags_q(flags_q), .cond(cond), .cond_pass(cond_pass),
    .cond_undef(cond_undef)
  );

  // {op, a, b, shift_carry, set_flags, exp_result, exp_wr, exp_flags NZCV, req}
  localparam int NV = 25;
  localparam logic [110:0] VEC [NV] = '{
    {4'd3,  32'h00000001, 32'h00000002, 1'b0, 1'b1, 32'h00000003, 1'b1, 4'b0000, 4'd4},  // R4
    {4'd3,  32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1, 32'h00000000, 1'b1, 4'b0110, 4'd4},  // R4
    {4'd4,  32'h00000000, 32'h00000000, 1'b0, 1'b1, 32'h00000001, 1'b1, 4'b0000, 4'd6},  // R6
    {4'd3,  32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b1, 32'h80000000, 1'b1, 4'b1001, 4'd5},  // R5
    {4'd3,  32'h00000005, 32'h00000005, 1'b0, 1'b0, 32'h0000000A, 1'b1, 4'b1001, 4'd2},  // R2
    {4'd10, 32'h00000003, 32'h00000005, 1'b0, 1'b0, 32'hFFFFFFFE, 1'b0, 4'b1000, 4'd3},  // R3
    {4'd10, 32'h00000005, 32'h00000003, 1'b0, 1'b0, 32'h00000002, 1'b0, 4'b0010, 4'd3},  // R3
    {4'd10, 32'h80000000, 32'h00000001, 1'b0, 1'b0, 32'h7FFFFFFF, 1'b0, 4'b0011, 4'd5},  // R5
    {4'd8,  32'h80000000, 32'h80000000, 1'b0, 1'b0, 32'h80000000, 1'b0, 4'b1001, 4'd7},  // R7
    {4'd2,  32'h00000007, 32'h00000007, 1'b0, 1'b1, 32'h00000000, 1'b1, 4'b0110, 4'd4},  // R4
    {4'd10, 32'h00000000, 32'h00000001, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b0, 4'b1000, 4'd4},  // R4
    {4'd5,  32'h0000000A, 32'h00000003, 1'b0, 1'b1, 32'h00000006, 1'b1, 4'b0010, 4'd6},  // R6
    {4'd5,  32'h0000000A, 32'h00000003, 1'b0, 1'b1, 32'h00000007, 1'b1, 4'b0010, 4'd6},  // R6
    {4'd9,  32'h000000FF, 32'h000000FF, 1'b1, 1'b0, 32'h00000000, 1'b0, 4'b0110, 4'd7},  // R7
    {4'd11, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h80000000, 1'b0, 4'b1001, 4'd3},  // R3
    {4'd15, 32'h12345678, 32'h00000009, 1'b1, 1'b1, 32'h00000000, 1'b0, 4'b1001, 4'd12}, // R12
    {4'd1,  32'h0000F0F0, 32'h0000FF00, 1'b1, 1'b0, 32'h00000FF0, 1'b1, 4'b1001, 4'd2},  // R2
    {4'd14, 32'h00000001, 32'h00000005, 1'b0, 1'b1, 32'h00000004, 1'b1, 4'b0010, 4'd4},  // R4
    {4'd13, 32'h00000000, 32'h00000000, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b1, 4'b1000, 4'd7},  // R7
    {4'd12, 32'h000000FF, 32'h0000000F, 1'b1, 1'b1, 32'h000000F0, 1'b1, 4'b0010, 4'd7},  // R7
    {4'd6,  32'h000000F0, 32'h0000000F, 1'b0, 1'b1, 32'h000000FF, 1'b1, 4'b0000, 4'd7},  // R7
    {4'd7,  32'h00000000, 32'h80000000, 1'b1, 1'b1, 32'h80000000, 1'b1, 4'b1010, 4'd7},  // R7
    {4'd0,  32'h000000F0, 32'h0000000F, 1'b1, 1'b1, 32'h00000000, 1'b1, 4'b0110, 4'd7},  // R7
    {4'd3,  32'h80000000, 32'h80000000, 1'b0, 1'b1, 32'h00000000, 1'b1, 4'b0111, 4'd5},  // R5
    {4'd0,  32'h000000FF, 32'h000000FF, 1'b0, 1'b1, 32'h000000FF, 1'b1, 4'b0001, 4'd7}   // R7
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8 R9 R10 R11: expected predicate from the flag values {N,Z,C,V}
  function automatic bit pred(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'd0: return z;          4'd1: return !z;
      4'd2: return cy;         4'd3: return !cy;
      4'd4: return n;          4'd5: return !n;
      4'd6: return v;          4'd7: return !v;
      4'd8: return cy && !z;   4'd9: return !cy || z;
      4'd10: return n == v;    4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweep_conds(input logic [3:0] f);
    for (int c = 0; c < 16; c++) begin
      cond = 4'(c);
      #1;
      if (c < 8)       check(cond_pass == pred(4'(c), f), "R8",  {31'd0, cond_pass}, {31'd0, pred(4'(c), f)});
      else if (c < 10) check(cond_pass == pred(4'(c), f), "R9",  {31'd0, cond_pass}, {31'd0, pred(4'(c), f)});
      else if (c < 14) check(cond_pass == pred(4'(c), f), "R10", {31'd0, cond_pass}, {31'd0, pred(4'(c), f)});
      else             check(cond_pass == pred(4'(c), f), "R11", {31'd0, cond_pass}, {31'd0, pred(4'(c), f)});
      check(cond_undef == (c == 15), "R11 undef", {31'd0, cond_undef}, {31'd0, (c == 15)});
    end
  endtask

  initial begin
    #3000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
    shift_carry = 1'b0; set_flags = 1'b0; cond = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(flags_q == 4'b0000, "R1 reset state", {28'd0, flags_q}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [110:0] v;
      v = VEC[i];
      @(negedge clk);
      op_valid = 1'b1;
      {op_sel, opnd_a, opnd_b, shift_carry, set_flags} = v[110:41];
      #2;
      check(result == v[40:9], $sformatf("R%0d result vec %0d", v[3:0], i), result, v[40:9]);
      check(wr_result == v[8], $sformatf("R3 write strobe vec %0d", i), {31'd0, wr_result}, {31'd0, v[8]});
      @(posedge clk);
      #2;
      op_valid = 1'b0;
      check(flags_q == v[7:4], $sformatf("R%0d flags vec %0d", v[3:0], i), {28'd0, flags_q}, {28'd0, v[7:4]});
      sweep_conds(v[7:4]);
    end

    // R2: idle cycle with a flag-setting op presented but op_valid low
    @(negedge clk);
    op_valid = 1'b0; op_sel = 4'd3; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h1; set_flags = 1'b1;
    @(posedge clk); #2;
    check(flags_q == 4'b0001, "R2 op_valid low", {28'd0, flags_q}, 32'h1);
    check(wr_result == 1'b0, "R2 no write when idle", {31'd0, wr_result}, 32'd0);

    // R1: reset clears nonzero flags even with an op presented
    @(negedge clk);
    op_valid = 1'b1; op_sel = 4'd10; opnd_a = 32'h3; opnd_b = 32'h5;
    @(posedge clk); #2;
    check(flags_q == 4'b1000, "R3 compare before reset", {28'd0, flags_q}, 32'h8);
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0; op_valid = 1'b0;
    check(flags_q == 4'b0000, "R1 reset clears", {28'd0, flags_q}, 32'd0);
    sweep_conds(4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule